// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Chain

This block holds the digital counter chain of an integer-N frequency synthesizer. A reference path divides crystal clock events by a ratio chosen from a small, sparse code table and produces the comparison pulse. A main path divides oscillator clock events by a 15-bit programmable ratio and produces the divided pulse. Both clocks arrive as single-cycle enables on one system clock, so each pulse stands for one edge of the slower clock. The tuning step equals the comparison rate: with a 4 MHz crystal, the legal codes give 2 MHz, 1 MHz, 500 kHz, 250 kHz or 125 kHz.

A third output stands in for the crystal buffer pin. A mode code selects what drives it: nothing, the crystal clock, or one of two test clocks that toggle on each divided pulse or on each comparison pulse. Ratio words are applied in a glitch-free way. A new value is picked up only when the running count reaches terminal, so no period is ever cut short. A reference code outside the table, or a main ratio below the legal floor, raises a registered configuration error flag. When that happens the block falls back to a safe ratio.

Top module: `synth_div_chain`

## Requirements
- R1: The main ratio `n_word` is a 15-bit unsigned value with bit 14 as its MSB; for a legal value N (64 to 32767), `div_pulse` fires once every N cycles in which `vco_en` is high, and never in the cycle after a cycle with `vco_en` low.
- R2: A main ratio below 64 (including 0) divides by 64, and `cfg_err` is 1 in the cycle after such a value is present.
- R3: `ref_code` selects the reference ratio: 3'b000 divides by 2, 3'b001 by 4, 3'b010 by 8, 3'b101 by 16, 3'b111 by 32; `comp_pulse` fires once every that many cycles with `xtal_en` high, and only after an `xtal_en` cycle.
- R4: Codes 3'b011, 3'b100 and 3'b110 are illegal: the reference path keeps the last legal ratio it saw (2 after reset), and `cfg_err` is 1 in the following cycle.
- R5: When `ref_code` is legal and `n_word` is at least 64, `cfg_err` is 0 in the following cycle.
- R6: A changed ratio takes effect only at the next terminal count; the period running when it changes completes with the old ratio.
- R7: Each pulse is high for exactly one cycle; the first enabled cycle after reset produces a pulse on both paths.
- R8: With `mode_code` 3'b000, `xo_out` is held at 0.
- R9: With `mode_code` 3'b010, `xo_out` changes level once per divided pulse, giving half the divided rate.
- R10: With `mode_code` 3'b101, `xo_out` changes level once per comparison pulse, giving a reference-derived test clock.
- R11: With any other `mode_code`, `xo_out` equals `xtal_en` delayed by one cycle.
- R12: During reset, `div_pulse`, `comp_pulse`, `xo_out` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_en | input | 1 | One event of the oscillator clock |
| xtal_en | input | 1 | One event of the crystal clock |
| n_word | input | 15 | Main divide ratio, unsigned |
| ref_code | input | 3 | Reference ratio select code |
| mode_code | input | 3 | Crystal output source select |
| comp_pulse | output | 1 | Comparison pulse, one cycle at reference terminal count |
| div_pulse | output | 1 | Divided pulse, one cycle at main terminal count |
| xo_out | output | 1 | Crystal buffer output level |
| cfg_err | output | 1 | Registered configuration error flag |

## Verification
The bench builds the block with its default parameters: a 15-bit main ratio with a floor of 64. This puts the clamp boundary, a ratio with bit 14 set and every entry of the reference table within reach within the run length. It measures pulse periods with both enables held high, and again with the oscillator enable present only every other cycle, to show that the counters count events and not clock cycles. Ratio changes are made mid-period to confirm the old period finishes intact. Illegal reference codes are written after a legal one, to confirm that the held ratio survives.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  localparam int REF_CODE_W  = 3;
  localparam int MODE_W      = 3;
  localparam int REF_RATIO_W = 6;

  localparam logic [MODE_W-1:0] XO_MODE_OFF      = 3'b000;
  localparam logic [MODE_W-1:0] XO_MODE_HALF_DIV = 3'b010;
  localparam logic [MODE_W-1:0] XO_MODE_REF_TEST = 3'b101;

  typedef struct packed {
    logic                   legal;
    logic [REF_RATIO_W-1:0] ratio;
  } ref_dec_t;

  typedef enum logic [1:0] {
    XO_SRC_OFF  = 2'd0,
    XO_SRC_XTAL = 2'd1,
    XO_SRC_DIV  = 2'd2,
    XO_SRC_REF  = 2'd3
  } xo_src_e;

  // Sparse reference table: the legal ratio is 2 to the power of an index.
  function automatic ref_dec_t decode_ref(input logic [REF_CODE_W-1:0] code);
    ref_dec_t d;
    d.legal = 1'b1;
    case (code)
      3'b000:  d.ratio = REF_RATIO_W'(2);
      3'b001:  d.ratio = REF_RATIO_W'(4);
      3'b010:  d.ratio = REF_RATIO_W'(8);
      3'b101:  d.ratio = REF_RATIO_W'(16);
      3'b111:  d.ratio = REF_RATIO_W'(32);
      default: begin
        d.legal = 1'b0;
        d.ratio = REF_RATIO_W'(2);
      end
    endcase
    return d;
  endfunction

  function automatic xo_src_e pick_xo_src(input logic [MODE_W-1:0] mode);
    case (mode)
      XO_MODE_OFF:      return XO_SRC_OFF;
      XO_MODE_HALF_DIV: return XO_SRC_DIV;
      XO_MODE_REF_TEST: return XO_SRC_REF;
      default:          return XO_SRC_XTAL;
    endcase
  endfunction

endpackage

// File: rtl/ref_ratio_sel.sv
module ref_ratio_sel
  import synth_div_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REF_CODE_W-1:0]  code,
  output logic [REF_RATIO_W-1:0] ratio,
  output logic                   illegal
);

  ref_dec_t                dec;
  logic [REF_RATIO_W-1:0]  hold_q;

  always_comb begin
    dec     = decode_ref(code);
    illegal = ~dec.legal;
    ratio   = dec.legal ? dec.ratio : hold_q;
  end

  // Remember the last legal ratio so an illegal code falls back to it.
  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= REF_RATIO_W'(2);
    else if (dec.legal) hold_q <= dec.ratio;
  end

endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         term,
  output logic         pulse
);

  logic [W-1:0] cnt_q;

  // Terminal count is the enabled cycle at zero; the ratio is sampled only here.
  assign term = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= term;
      if (term)    cnt_q <= ratio - W'(1);
      else if (en) cnt_q <= cnt_q - W'(1);
    end
  end

endmodule

// File: rtl/xo_mux.sv
module xo_mux
  import synth_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              xtal_en,
  input  logic              div_pulse,
  input  logic              comp_pulse,
  output logic              xo
);

  xo_src_e src;
  logic    div_tgl_q;
  logic    ref_tgl_q;
  logic    xo_d;

  assign src = pick_xo_src(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_tgl_q <= 1'b0;
      ref_tgl_q <= 1'b0;
    end else begin
      if (div_pulse)  div_tgl_q <= ~div_tgl_q;
      if (comp_pulse) ref_tgl_q <= ~ref_tgl_q;
    end
  end

  always_comb begin
    case (src)
      XO_SRC_OFF:  xo_d = 1'b0;
      XO_SRC_DIV:  xo_d = div_tgl_q;
      XO_SRC_REF:  xo_d = ref_tgl_q;
      default:     xo_d = xtal_en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) xo <= 1'b0;
    else        xo <= xo_d;
  end

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
#(
  parameter int N_W   = 15,
  parameter int N_MIN = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vco_en,
  input  logic                  xtal_en,
  input  logic [N_W-1:0]        n_word,
  input  logic [REF_CODE_W-1:0] ref_code,
  input  logic [MODE_W-1:0]     mode_code,
  output logic                  comp_pulse,
  output logic                  div_pulse,
  output logic                  xo_out,
  output logic                  cfg_err
);

  localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

  logic [N_W-1:0]         n_eff;
  logic                   n_low;
  logic [REF_RATIO_W-1:0] r_eff;
  logic                   r_bad;
  logic                   main_term;
  logic                   ref_term;
  logic                   err_q;

  assign n_low = n_word < N_FLOOR;
  assign n_eff = n_low ? N_FLOOR : n_word;

  ref_ratio_sel u_ref_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (ref_code),
    .ratio   (r_eff),
    .illegal (r_bad)
  );

  prog_counter #(.W(REF_RATIO_W)) u_ref_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (xtal_en),
    .ratio (r_eff),
    .term  (ref_term),
    .pulse (comp_pulse)
  );

  prog_counter #(.W(N_W)) u_main_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (vco_en),
    .ratio (n_eff),
    .term  (main_term),
    .pulse (div_pulse)
  );

  xo_mux u_xo (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_code),
    .xtal_en    (xtal_en),
    .div_pulse  (div_pulse),
    .comp_pulse (comp_pulse),
    .xo         (xo_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= n_low | r_bad;
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk
  import synth_div_pkg::*;
#(
  parameter int N_W   = 15,
  parameter int N_MIN = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  vco_en,
  input logic                  xtal_en,
  input logic [N_W-1:0]        n_word,
  input logic [REF_CODE_W-1:0] ref_code,
  input logic [MODE_W-1:0]     mode_code,
  input logic                  comp_pulse,
  input logic                  div_pulse,
  input logic                  xo_out,
  input logic                  cfg_err
);

  logic code_bad;
  logic mode_plain;
  assign code_bad   = (ref_code == 3'b011) || (ref_code == 3'b100) || (ref_code == 3'b110);
  assign mode_plain = (mode_code != 3'b000) && (mode_code != 3'b010) && (mode_code != 3'b101);

  assert_div_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_en |=> !div_pulse);

  assert_clamp_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (n_word < N_W'(N_MIN)) |=> cfg_err);

  assert_comp_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |=> !comp_pulse);

  assert_illegal_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_bad |=> cfg_err);

  assert_clean_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_bad && n_word >= N_W'(N_MIN)) |=> !cfg_err);

  assert_div_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_comp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    comp_pulse |=> !comp_pulse);

  assert_xo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'b000) |=> !xo_out);

  assert_xo_xtal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_plain |=> (xo_out == $past(xtal_en)));

endmodule

bind synth_div_chain synth_div_chain_chk #(.N_W(N_W), .N_MIN(N_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vco_en     (vco_en),
  .xtal_en    (xtal_en),
  .n_word     (n_word),
  .ref_code   (ref_code),
  .mode_code  (mode_code),
  .comp_pulse (comp_pulse),
  .div_pulse  (div_pulse),
  .xo_out     (xo_out),
  .cfg_err    (cfg_err)
);

// File: tb/tb_synth_div_chain.sv
module tb_synth_div_chain;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vco_en = 1'b0;
  logic        xtal_en = 1'b0;
  logic [14:0] n_word;
  logic [2:0]  ref_code;
  logic [2:0]  mode_code;
  logic        comp_pulse, div_pulse, xo_out, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int vco_gap = 1;
  int xtal_gap = 1;
  int last_div = -1;
  int last_comp = -1;
  int    div_q[$];
  string div_tag[$];
  int    comp_q[$];
  string comp_tag[$];

  always #10 clk = ~clk;

  synth_div_chain dut (
    .clk(clk), .rst_n(rst_n), .vco_en(vco_en), .xtal_en(xtal_en),
    .n_word(n_word), .ref_code(ref_code), .mode_code(mode_code),
    .comp_pulse(comp_pulse), .div_pulse(div_pulse), .xo_out(xo_out), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stimulus for the enables plus the scoreboard monitor, all at the falling edge.
  always @(negedge clk) begin
    cyc++;
    vco_en  <= (cyc % vco_gap) == 0;
    xtal_en <= (cyc % xtal_gap) == 0;
    if (div_pulse) begin
      if (last_div >= 0 && div_q.size() > 0)
        check(cyc - last_div == div_q[0], div_tag[0], cyc - last_div, div_q[0]);
      if (div_q.size() > 0) begin
        void'(div_q.pop_front());
        void'(div_tag.pop_front());
      end
      last_div = cyc;
    end
    if (comp_pulse) begin
      if (last_comp >= 0 && comp_q.size() > 0)
        check(cyc - last_comp == comp_q[0], comp_tag[0], cyc - last_comp, comp_q[0]);
      if (comp_q.size() > 0) begin
        void'(comp_q.pop_front());
        void'(comp_tag.pop_front());
      end
      last_comp = cyc;
    end
  end

  task automatic wait_div(input int k);
    int seen = 0;
    while (seen < k) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
  endtask

  task automatic wait_comp(input int k);
    int seen = 0;
    while (seen < k) begin
      @(negedge clk);
      if (comp_pulse) seen++;
    end
  endtask

  task automatic main_run(input int n, input int gap, input int exp, input int periods, input string tag);
    n_word  = 15'(n);
    vco_gap = gap;
    wait_div(2);
    for (int i = 0; i < periods; i++) begin
      div_q.push_back(exp);
      div_tag.push_back(tag);
    end
    while (div_q.size() != 0) @(negedge clk);
  endtask

  task automatic ref_run(input logic [2:0] code, input int exp, input int periods, input string tag);
    ref_code = code;
    wait_comp(2);
    for (int i = 0; i < periods; i++) begin
      comp_q.push_back(exp);
      comp_tag.push_back(tag);
    end
    while (comp_q.size() != 0) @(negedge clk);
  endtask

  task automatic err_check(input bit exp, input string tag);
    repeat (2) @(negedge clk);
    check(cfg_err == exp, tag, cfg_err, exp);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int local_cnt;
    logic old_xo;
    rst_n     = 1'b0;
    n_word    = 15'd100;
    ref_code  = 3'b000;
    mode_code = 3'b100;
    repeat (5) @(negedge clk);
    // R12: outputs quiet in reset
    check(div_pulse == 0 && comp_pulse == 0, "R12", {div_pulse, comp_pulse}, 0);
    check(xo_out == 0 && cfg_err == 0, "R12", {xo_out, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: first enabled cycle produces a pulse on both paths
    check(div_pulse == 1 && comp_pulse == 1, "R7", {div_pulse, comp_pulse}, 3);
    @(negedge clk);
    check(div_pulse == 0, "R7", div_pulse, 0);
    // R11: crystal mode follows xtal_en
    check(xo_out == 1, "R11", xo_out, 1);
    err_check(1'b0, "R5");

    // R1: main divider under several ratios and enable patterns
    main_run(100, 1, 100, 3, "R1");
    main_run(64, 1, 64, 3, "R1");
    main_run(1000, 2, 2000, 2, "R1");
    main_run(16385, 1, 16385, 2, "R1");
    // R2: clamp below floor
    main_run(10, 1, 64, 2, "R2");
    check(cfg_err == 1, "R2", cfg_err, 1);
    main_run(0, 1, 64, 2, "R2");
    check(cfg_err == 1, "R2", cfg_err, 1);
    main_run(64, 1, 64, 1, "R5");
    err_check(1'b0, "R5");

    // R6: change mid-period, current period completes
    main_run(200, 1, 200, 1, "R6");
    wait_div(1);
    local_cnt = 0;
    repeat (50) begin @(negedge clk); local_cnt++; end
    n_word = 15'd64;
    while (1) begin
      @(negedge clk);
      local_cnt++;
      if (div_pulse) break;
    end
    check(local_cnt == 200, "R6", local_cnt, 200);
    local_cnt = 0;
    while (1) begin
      @(negedge clk);
      local_cnt++;
      if (div_pulse) break;
    end
    check(local_cnt == 64, "R6", local_cnt, 64);

    // R3: reference table
    ref_run(3'b000, 2, 3, "R3");
    ref_run(3'b001, 4, 3, "R3");
    ref_run(3'b010, 8, 3, "R3");
    ref_run(3'b101, 16, 3, "R3");
    ref_run(3'b111, 32, 3, "R3");
    // R4: illegal codes hold last legal ratio (32)
    ref_run(3'b011, 32, 2, "R4");
    check(cfg_err == 1, "R4", cfg_err, 1);
    ref_run(3'b101, 16, 1, "R3");
    ref_run(3'b100, 16, 2, "R4");
    check(cfg_err == 1, "R4", cfg_err, 1);
    ref_run(3'b110, 16, 2, "R4");
    check(cfg_err == 1, "R4", cfg_err, 1);
    ref_run(3'b000, 2, 2, "R3");
    err_check(1'b0, "R5");

    // R8: output off
    mode_code = 3'b000;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(xo_out == 0, "R8", xo_out, 0);
    end

    // R11: gapped crystal in two plain modes
    xtal_gap = 3;
    mode_code = 3'b001;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      check(xo_out == xtal_en, "R11", xo_out, xtal_en);
    end
    mode_code = 3'b111;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(xo_out == xtal_en, "R11", xo_out, xtal_en);
    end
    xtal_gap = 1;

    // R9: half divided rate
    mode_code = 3'b010;
    wait_div(1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      old_xo = xo_out;
      wait_div(1);
      repeat (3) @(negedge clk);
      check(xo_out != old_xo, "R9", xo_out, !old_xo);
    end

    // R10: reference-derived test clock
    ref_code  = 3'b111;
    mode_code = 3'b101;
    wait_comp(2);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      old_xo = xo_out;
      wait_comp(1);
      repeat (3) @(negedge clk);
      check(xo_out != old_xo, "R10", xo_out, !old_xo);
    end

    summary();
    $finish;
  end

endmodule